// File: doc/BRIEF.md
# Victim Persistence Cache

This block sits next to the memory controller. It absorbs dirty lines in the persistent address range that the last-level cache evicts, so that uncommitted data never reaches its home location in persistent memory. Each absorbed line is kept in a small fully associative array with its address, its data and the token of the transaction that last wrote it. A read miss from the cache hierarchy is looked up in the same cycle. On a hit, the stored line is returned in place of the persistent-memory contents.

The background log-copy engine retires entries with delete requests. A delete takes effect only when the entry still belongs to the copying transaction: either its token equals the entry's last-writer token, or, in the alternate mode, the value being copied equals the stored value. When a new line arrives and no entry is free, the line is not stored and a sticky overflow flag is raised, so the system can switch to its degraded path. A single flush pulse at restart empties the whole array and clears the flag.

Top module: `vpc_top`

## Requirements
- R1: An insert to an address that is not present stores the address, data and token in a free entry. From the next cycle, a lookup of that address returns hit = 1 with that data.
- R2: A lookup whose address matches no valid entry returns hit = 0 and data = 0. A lookup with its valid input low also returns hit = 0.
- R3: An insert to an address that is already present overwrites that entry's data and token and does not use a second entry. Re-inserting a present address when the array is full therefore does not raise overflow.
- R4: In token mode (mode input = 0), a delete removes the matching entry only when the delete token equals the entry's last-writer token. Otherwise the entry stays unchanged.
- R5: In value mode (mode input = 1), a delete removes the matching entry only when the delete data equals the stored data, whatever the token.
- R6: After an entry is removed, a lookup of its address misses (hit = 0).
- R7: An insert of a new address while every entry is valid stores nothing and leaves the existing entries intact. The overflow output rises at the following clock edge and stays high until a flush.
- R8: A flush invalidates every entry and clears overflow. From the next cycle, all lookups miss.
- R9: A lookup made in the same cycle as a delete of the same address sees the contents from before the delete.
- R10: An insert and a delete that target the same present address in the same cycle leave the entry valid, holding the inserted data.
- R11: A flush takes priority over an insert, a delete or an overflow in the same cycle: after it, nothing is stored and overflow is low.
- R12: After reset, no entry is valid and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries and clear overflow |
| ins_valid_i | input | 1 | Eviction insert request |
| ins_addr_i | input | ADDR_W | Line address of the evicted line |
| ins_data_i | input | DATA_W | Data of the evicted line |
| ins_token_i | input | TOKEN_W | Token of the writing transaction |
| rd_valid_i | input | 1 | Lookup request for a read miss |
| rd_addr_i | input | ADDR_W | Lookup address |
| rd_hit_o | output | 1 | Lookup address found in the array |
| rd_data_o | output | DATA_W | Data of the hit entry, zero on a miss |
| del_valid_i | input | 1 | Conditional delete request |
| del_mode_i | input | 1 | 0 = compare token, 1 = compare value |
| del_addr_i | input | ADDR_W | Address to retire |
| del_token_i | input | TOKEN_W | Token of the copying transaction |
| del_data_i | input | DATA_W | Value being copied home |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach are the collisions between ports in one cycle: an insert and a delete on the same entry, a lookup racing a delete, and a new line arriving just as the array fills. A plain stream of random traffic rarely lines these up. The stimulus draws addresses, tokens and values from small pools so that hits, token matches and value matches happen often and the eight entries fill repeatedly. Directed sequences also force each collision explicitly: same-cycle insert with delete, lookup with delete, and flush with insert.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic {
    DEL_BY_TOKEN = 1'b0,
    DEL_BY_VALUE = 1'b1
  } del_mode_e;
endpackage

// File: rtl/vpc_cam.sv
module vpc_cam #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        key_i,
  output logic [N-1:0]         hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/vpc_pick_free.sv
module vpc_pick_free #(
  parameter int N = 8
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pri
    assign pick_o[g]  = !valid_i[g] && !seen[g];
    assign seen[g+1]  = seen[g] || !valid_i[g];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/vpc_onehot_mux.sv
module vpc_onehot_mux #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic [N-1:0]        sel_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic [W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) data_o = data_o | data_i[i];
    end
  end
endmodule

// File: rtl/vpc_store.sv
module vpc_store #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic [N-1:0]         wr_i,
  input  logic [N-1:0]         clr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic [TW-1:0]        token_i,
  output logic [N-1:0]         valid_q,
  output logic [N-1:0][AW-1:0] tag_q,
  output logic [N-1:0][DW-1:0] data_q,
  output logic [N-1:0][TW-1:0] tok_q
);
  logic [N-1:0] valid_d;

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < N; i++) begin
      if (flush_i)       valid_d[i] = 1'b0;
      else if (wr_i[i])  valid_d[i] = 1'b1;
      else if (clr_i[i]) valid_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr_en;
    assign wr_en = wr_i[g] && !flush_i;
    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[g]  <= addr_i;
        data_q[g] <= data_i;
        tok_q[g]  <= token_i;
      end
    end
  end
endmodule

// File: rtl/vpc_top.sv
module vpc_top #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TOKEN_W = 8,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               ins_valid_i,
  input  logic [ADDR_W-1:0]  ins_addr_i,
  input  logic [DATA_W-1:0]  ins_data_i,
  input  logic [TOKEN_W-1:0] ins_token_i,
  input  logic               rd_valid_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               rd_hit_o,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               del_valid_i,
  input  logic               del_mode_i,
  input  logic [ADDR_W-1:0]  del_addr_i,
  input  logic [TOKEN_W-1:0] del_token_i,
  input  logic [DATA_W-1:0]  del_data_i,
  output logic               ovf_o
);
  import vpc_pkg::*;

  localparam int N = DEPTH;

  logic [N-1:0]              valid_q;
  logic [N-1:0][ADDR_W-1:0]  tag_q;
  logic [N-1:0][DATA_W-1:0]  data_q;
  logic [N-1:0][TOKEN_W-1:0] tok_q;

  logic [N-1:0] ins_hit_vec, rd_hit_vec, del_hit_vec, free_vec;
  logic [N-1:0] wr_vec, clr_vec;
  logic         ins_hit, any_free, ovf_set, ovf_q, ovf_d, del_ok;
  logic [DATA_W-1:0]  rd_mux, del_dat;
  logic [TOKEN_W-1:0] del_tok;
  del_mode_e          mode;

  vpc_cam #(.N(N), .AW(ADDR_W)) u_cam_ins (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(ins_addr_i), .hit_o(ins_hit_vec));
  vpc_cam #(.N(N), .AW(ADDR_W)) u_cam_rd (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(rd_addr_i), .hit_o(rd_hit_vec));
  vpc_cam #(.N(N), .AW(ADDR_W)) u_cam_del (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(del_addr_i), .hit_o(del_hit_vec));

  vpc_pick_free #(.N(N)) u_free (
    .valid_i(valid_q), .pick_o(free_vec), .any_o(any_free));

  vpc_onehot_mux #(.N(N), .W(DATA_W)) u_mux_rd (
    .sel_i(rd_hit_vec), .data_i(data_q), .data_o(rd_mux));
  vpc_onehot_mux #(.N(N), .W(DATA_W)) u_mux_deld (
    .sel_i(del_hit_vec), .data_i(data_q), .data_o(del_dat));
  vpc_onehot_mux #(.N(N), .W(TOKEN_W)) u_mux_delt (
    .sel_i(del_hit_vec), .data_i(tok_q), .data_o(del_tok));

  assign ins_hit = |ins_hit_vec;
  assign mode    = del_mode_e'(del_mode_i);

  always_comb begin
    wr_vec  = '0;
    ovf_set = 1'b0;
    if (ins_valid_i && !flush_i) begin
      if (ins_hit)       wr_vec  = ins_hit_vec;
      else if (any_free) wr_vec  = free_vec;
      else               ovf_set = 1'b1;
    end
  end

  always_comb begin
    if (mode == DEL_BY_TOKEN) del_ok = (del_tok == del_token_i);
    else                      del_ok = (del_dat == del_data_i);
    clr_vec = '0;
    if (del_valid_i && !flush_i && del_ok) clr_vec = del_hit_vec & ~wr_vec;
  end

  vpc_store #(.N(N), .AW(ADDR_W), .DW(DATA_W), .TW(TOKEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_i(wr_vec), .clr_i(clr_vec),
    .addr_i(ins_addr_i), .data_i(ins_data_i), .token_i(ins_token_i),
    .valid_q(valid_q), .tag_q(tag_q), .data_q(data_q), .tok_q(tok_q));

  always_comb begin
    if (flush_i) ovf_d = 1'b0;
    else         ovf_d = ovf_q || ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_o     = ovf_q;
  assign rd_hit_o  = rd_valid_i && (|rd_hit_vec);
  assign rd_data_o = rd_hit_o ? rd_mux : '0;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             ins_valid_i,
  input logic             del_valid_i,
  input logic             ins_hit,
  input logic             any_free,
  input logic             rd_hit_o,
  input logic             ovf_o,
  input logic [DEPTH-1:0] rd_hit_vec,
  input logic [DEPTH-1:0] valid_q
);
  // R3: one address never occupies two entries
  a_r3_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit_vec));

  // R7: a new line that finds no room raises overflow
  a_r7_no_overflow_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !flush_i && !ins_hit && !any_free) |=> ovf_o);

  // R8: flush empties the array and clears overflow
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!rd_hit_o && !ovf_o && (valid_q == '0)));

  // R1: without flush or delete, occupancy never drops
  a_r1_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !del_valid_i) |=> ($countones(valid_q) >= $past($countones(valid_q))));

  // R7: overflow only rises after an insert
  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(ins_valid_i));
endmodule

bind vpc_top vpc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ins_valid_i(ins_valid_i),
  .del_valid_i(del_valid_i), .ins_hit(ins_hit), .any_free(any_free),
  .rd_hit_o(rd_hit_o), .ovf_o(ovf_o), .rd_hit_vec(rd_hit_vec), .valid_q(valid_q));

// File: tb/vpc_top_tb.sv
module vpc_top_tb_top;
  localparam int AW = 16, DW = 32, TW = 8, N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic flush_i, ins_valid_i, rd_valid_i, del_valid_i, del_mode_i;
  logic [AW-1:0] ins_addr_i, rd_addr_i, del_addr_i;
  logic [DW-1:0] ins_data_i, del_data_i, rd_data_o;
  logic [TW-1:0] ins_token_i, del_token_i;
  logic rd_hit_o, ovf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  logic [TW-1:0] m_t [N];
  logic          m_ovf;

  always #5 clk = ~clk;

  vpc_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i), .ins_data_i(ins_data_i),
    .ins_token_i(ins_token_i), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
    .rd_hit_o(rd_hit_o), .rd_data_o(rd_data_o), .del_valid_i(del_valid_i),
    .del_mode_i(del_mode_i), .del_addr_i(del_addr_i), .del_token_i(del_token_i),
    .del_data_i(del_data_i), .ovf_o(ovf_o));

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    flush_i = 0; ins_valid_i = 0; rd_valid_i = 0; del_valid_i = 0; del_mode_i = 0;
    ins_addr_i = '0; ins_data_i = '0; ins_token_i = '0; rd_addr_i = '0;
    del_addr_i = '0; del_token_i = '0; del_data_i = '0;
  endtask

  task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs are set; compare outputs, clock once, update model, return at negedge.
  task automatic step(string tag);
    int idx, ih, dh, fr, w;
    logic eh;
    logic [DW-1:0] ed;
    #1;
    idx = find(rd_addr_i);
    eh  = rd_valid_i && (idx >= 0);
    ed  = eh ? m_d[idx] : '0;
    if (rd_valid_i) check({tag, " read"}, {rd_hit_o, rd_data_o}, {eh, ed});
    check({tag, " ovf"}, {{DW{1'b0}}, ovf_o}, {{DW{1'b0}}, m_ovf});
    ih = find(ins_addr_i); dh = find(del_addr_i); fr = first_free();
    @(posedge clk);
    if (flush_i) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ovf = 0;
    end else begin
      w = -1;
      if (ins_valid_i) begin
        if (ih >= 0) w = ih;
        else if (fr >= 0) w = fr;
        else m_ovf = 1;
      end
      if (del_valid_i && dh >= 0 && dh != w &&
          (del_mode_i ? (m_d[dh] == del_data_i) : (m_t[dh] == del_token_i)))
        m_v[dh] = 0;
      if (w >= 0) begin
        m_v[w] = 1; m_a[w] = ins_addr_i; m_d[w] = ins_data_i; m_t[w] = ins_token_i;
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic ins(logic [AW-1:0] a, logic [DW-1:0] d, logic [TW-1:0] t, string tag);
    ins_valid_i = 1; ins_addr_i = a; ins_data_i = d; ins_token_i = t;
    step(tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    rd_valid_i = 1; rd_addr_i = a;
    step(tag);
  endtask

  task automatic del(logic [AW-1:0] a, logic m, logic [TW-1:0] t, logic [DW-1:0] d, string tag);
    del_valid_i = 1; del_addr_i = a; del_mode_i = m; del_token_i = t; del_data_i = d;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; m_d[i] = '0; m_t[i] = '0; end
    m_ovf = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12: empty after reset
    rd(16'h0010, "R12 reset miss");
    // R2: lookup with valid low reports no hit
    rd_addr_i = 16'h0010; #1;
    check("R2 no request", {rd_hit_o, rd_data_o}, '0);
    @(negedge clk);
    // R1
    ins(16'h0100, 32'h11, 8'd1, "R1 insert");
    rd(16'h0100, "R1 hit");
    rd(16'h0101, "R2 miss");
    // R3 overwrite
    ins(16'h0100, 32'h22, 8'd2, "R3 overwrite");
    rd(16'h0100, "R3 new data");
    // R4 token mode
    del(16'h0100, 1'b0, 8'd1, 32'h22, "R4 stale token");
    rd(16'h0100, "R4 kept");
    // R9 lookup during delete sees old contents
    rd_valid_i = 1; rd_addr_i = 16'h0100;
    del(16'h0100, 1'b0, 8'd2, 32'h0, "R9 same-cycle read");
    rd(16'h0100, "R6 miss after delete");
    // R5 value mode
    ins(16'h0200, 32'h55, 8'd3, "R5 insert");
    del(16'h0200, 1'b1, 8'd3, 32'h54, "R5 wrong value");
    rd(16'h0200, "R5 kept");
    del(16'h0200, 1'b1, 8'd9, 32'h55, "R5 value match");
    rd(16'h0200, "R6 value miss");
    // R7 fill, overwrite when full, then overflow
    for (int i = 0; i < N; i++) ins(16'h0300 + 16'(i), 32'h1000 + 32'(i), 8'd4, "R7 fill");
    ins(16'h0303, 32'hABCD, 8'd5, "R3 full overwrite");
    rd(16'h0303, "R3 full data");
    ins(16'h0400, 32'h9999, 8'd6, "R7 overflow insert");
    rd(16'h0400, "R7 not stored");
    rd(16'h0300, "R7 kept entry");
    rd(16'h0307, "R7 kept entry");
    // R8 flush
    flush_i = 1; step("R8 flush");
    rd(16'h0300, "R8 miss after flush");
    // R10 insert and delete same address
    ins(16'h0500, 32'h77, 8'd7, "R10 setup");
    ins_valid_i = 1; ins_addr_i = 16'h0500; ins_data_i = 32'h78; ins_token_i = 8'd8;
    del(16'h0500, 1'b0, 8'd7, 32'h77, "R10 collide");
    rd(16'h0500, "R10 insert wins");
    // R11 flush beats insert
    flush_i = 1;
    ins(16'h0600, 32'h66, 8'd1, "R11 flush+insert");
    rd(16'h0600, "R11 not stored");
    rd(16'h0500, "R11 cleared");

    // random traffic over small pools
    for (int c = 0; c < 4000; c++) begin
      ins_valid_i = ($urandom % 10) < 4;
      ins_addr_i  = 16'h0700 + 16'($urandom % 12);
      ins_data_i  = 32'($urandom % 4);
      ins_token_i = 8'($urandom % 4);
      del_valid_i = ($urandom % 10) < 3;
      del_mode_i  = 1'($urandom % 2);
      del_addr_i  = 16'h0700 + 16'($urandom % 12);
      del_data_i  = 32'($urandom % 4);
      del_token_i = 8'($urandom % 4);
      rd_valid_i  = ($urandom % 10) < 7;
      rd_addr_i   = 16'h0700 + 16'($urandom % 12);
      flush_i     = ($urandom % 100) == 0;
      step("R1 R4 R5 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule